// File: doc/BRIEF.md
# Banked Pin Interrupt Controller

This block watches a large set of general-purpose input pins, arranged in banks of up to eight, and turns activity on them into one shared interrupt request. Each pin is given its own trigger rule: a high or low level, a rising or falling transition, or a transition in either direction. A pin whose rule is met latches a pending flag. Software reads the flags, acknowledges them, and decides through a per-pin mask which of them may reach the shared interrupt line.

Every bank owns three words on a small register bus: a trigger word, a mask word and a pending word. The three kinds of word sit in three separate arrays, with one word per bank at a stride of four bytes. Pin inputs are first synchronised to the block clock. Detection then runs on the synchronised values.

Top module: `gpio_bank_irq_ctrl`

## Requirements
- R1: While reset is active and right after it, every trigger word reads 0x00000000, every mask word reads 0x000000FF, every pending word reads 0, and `irq_out` is low.
- R2: The trigger word of bank g is at 0x700+4g, the mask word at 0x900+4g and the pending word at 0xA00+4g, for g from 0 to 21. The trigger word stores all 32 written bits. Pin n of a bank uses trigger bits [4n+3:4n]. The mask word keeps only bits [7:0], and bit n belongs to pin n.
- R3: Trigger code 3 sets pending bit n on a 0-to-1 change of pin n. Code 2 sets it on a 1-to-0 change. Code 4 sets it on either change. In these edge codes, a clear stays in effect while the pin holds still.
- R4: Code 1 (high level) and code 0 (low level) set the pending bit on every cycle the level is active. The bit stays latched after the level ends, until it is cleared.
- R5: Codes 5 to 15 never set the pending bit, whatever the pin does.
- R6: Writing pending bit n as 1 clears it. Writing it as 0 leaves it unchanged.
- R7: When a detected event and a write-1 clear of the same bit fall in the same cycle, the bit stays set.
- R8: Pending bits are set regardless of the mask. `irq_out` is high exactly when some bank has a pending bit whose mask bit is 0.
- R9: Reads of any address that is not one of the 66 words above (unaligned, past bank 21, or outside the arrays) return 0. Writes to such addresses change no register.
- R10: Each pin passes through two synchronising flops and one history flop. After a change is driven just before clock edge 1, the pending bit reads 0 after edge 2 and reads 1 after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 176 | Pin inputs; pin n of bank g is bit 8g+n |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a new event on the same pin. With edge triggers this needs the input edge and the bus write to line up through three flops of latency. The bench reaches it with a level trigger instead. An active level raises an event on every cycle, so any write-1 to that pending bit is certain to collide with an event, and the bit must read back as set. Exact latency is covered by driving a pin on a falling clock edge and reading the pending word at the falling edges after the second and third rising edges.

// File: rtl/gbi_pkg.sv
package gbi_pkg;

  typedef enum logic [3:0] {
    TRIG_LVL_LO = 4'd0,
    TRIG_LVL_HI = 4'd1,
    TRIG_FALL   = 4'd2,
    TRIG_RISE   = 4'd3,
    TRIG_BOTH   = 4'd4
  } trig_e;

  // One pin's detection rule: current synchronised value and previous value
  function automatic logic trig_hit(input logic [3:0] code,
                                    input logic       cur,
                                    input logic       prv);
    logic hit;
    case (code)
      TRIG_LVL_LO: hit = !cur;
      TRIG_LVL_HI: hit = cur;
      TRIG_FALL:   hit = !cur && prv;
      TRIG_RISE:   hit = cur && !prv;
      TRIG_BOTH:   hit = cur ^ prv;
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gbi_sync.sv
module gbi_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/gbi_bank.sv
module gbi_bank #(
  parameter int PINS  = 8,
  localparam int CFG_W = 4 * PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  pin_s,
  input  logic             cfg_we,
  input  logic             msk_we,
  input  logic             pnd_we,
  input  logic [CFG_W-1:0] wr_cfg,
  input  logic [PINS-1:0]  wr_bits,
  output logic [CFG_W-1:0] cfg_q,
  output logic [PINS-1:0]  msk_q,
  output logic [PINS-1:0]  pnd_q,
  output logic             bank_irq
);

  logic [CFG_W-1:0] cfg_d;
  logic [PINS-1:0]  msk_d;
  logic [PINS-1:0]  pnd_d;
  logic [PINS-1:0]  prv_q;
  logic [PINS-1:0]  evt;
  logic [PINS-1:0]  clr;

  // Next-state logic
  always_comb begin
    for (int n = 0; n < PINS; n++) begin
      evt[n] = gbi_pkg::trig_hit(cfg_q[4*n +: 4], pin_s[n], prv_q[n]);
    end
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = wr_cfg;
    msk_d = msk_q;
    if (msk_we) msk_d = wr_bits;
    clr = '0;
    if (pnd_we) clr = wr_bits;
    // A new event outranks a clear of the same bit
    pnd_d = (pnd_q & ~clr) | evt;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      msk_q <= '1;
      pnd_q <= '0;
      prv_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      msk_q <= msk_d;
      pnd_q <= pnd_d;
      prv_q <= pin_s;
    end
  end

  assign bank_irq = |(pnd_q & ~msk_q);

  // R3/R4: every detected event is latched on the next edge
  a_r3_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pnd_q & $past(evt)) == $past(evt)));

  // R6: no pending bit drops unless a 1 was written to it
  a_r6_only_write1_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
      ((($past(pnd_q) & ~($past(pnd_we) ? $past(wr_bits) : '0)) & ~pnd_q) == '0));

  // R5: no pending bit rises without a detected event
  a_r5_no_set_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pnd_q & ~$past(pnd_q) & ~$past(evt)) == '0));

  // R2: trigger word holds when not written
  a_r2_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_we)) |-> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/gpio_bank_irq_ctrl.sv
module gpio_bank_irq_ctrl #(
  parameter int NUM_BANKS     = 22,
  parameter int PINS_PER_BANK = 8,
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 32,
  parameter int CFG_BASE      = 'h700,
  parameter int MSK_BASE      = 'h900,
  parameter int PND_BASE      = 'hA00,
  localparam int NPIN         = NUM_BANKS * PINS_PER_BANK,
  localparam int CFG_W        = 4 * PINS_PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  localparam int P = PINS_PER_BANK;

  logic              rst_n_int;
  logic [NPIN-1:0]   pin_s;
  logic [NUM_BANKS-1:0] cfg_hit;
  logic [NUM_BANKS-1:0] msk_hit;
  logic [NUM_BANKS-1:0] pnd_hit;
  logic [NUM_BANKS-1:0] bank_irq;
  logic [CFG_W-1:0]  cfg_arr [NUM_BANKS];
  logic [P-1:0]      msk_arr [NUM_BANKS];
  logic [P-1:0]      pnd_arr [NUM_BANKS];
  logic [NPIN-1:0]   msk_flat;
  logic [NPIN-1:0]   pnd_flat;

  // Reset: asserted asynchronously, released on the clock
  gbi_sync #(.W(1)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_int)
  );

  gbi_sync #(.W(NPIN)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (pin_in),
    .q     (pin_s)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign cfg_hit[g] = (bus_addr == ADDR_W'(CFG_BASE + 4 * g));
    assign msk_hit[g] = (bus_addr == ADDR_W'(MSK_BASE + 4 * g));
    assign pnd_hit[g] = (bus_addr == ADDR_W'(PND_BASE + 4 * g));

    gbi_bank #(.PINS(P)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .pin_s    (pin_s[g*P +: P]),
      .cfg_we   (bus_we && cfg_hit[g]),
      .msk_we   (bus_we && msk_hit[g]),
      .pnd_we   (bus_we && pnd_hit[g]),
      .wr_cfg   (bus_wdata[CFG_W-1:0]),
      .wr_bits  (bus_wdata[P-1:0]),
      .cfg_q    (cfg_arr[g]),
      .msk_q    (msk_arr[g]),
      .pnd_q    (pnd_arr[g]),
      .bank_irq (bank_irq[g])
    );

    assign msk_flat[g*P +: P] = msk_arr[g];
    assign pnd_flat[g*P +: P] = pnd_arr[g];
  end

  // Read mux; unmatched addresses read zero
  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NUM_BANKS; g++) begin
      if (cfg_hit[g]) bus_rdata = bus_rdata | DATA_W'(cfg_arr[g]);
      if (msk_hit[g]) bus_rdata = bus_rdata | DATA_W'(msk_arr[g]);
      if (pnd_hit[g]) bus_rdata = bus_rdata | DATA_W'(pnd_arr[g]);
    end
  end

  assign irq_out = |bank_irq;

  // R9: an address selects at most one register array
  a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0({|cfg_hit, |msk_hit, |pnd_hit}));

  // R8: shared request tracks unmasked pending bits of all banks
  a_r8_irq_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_out == |(pnd_flat & ~msk_flat));

endmodule

// File: tb/sim_gpio_bank_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_irq_ctrl;

  localparam int NB = 22;
  localparam logic [11:0] CFG = 12'h700;
  localparam logic [11:0] MSK = 12'h900;
  localparam logic [11:0] PND = 12'hA00;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [175:0]  pins;
  logic [11:0]   bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_bank_irq_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pins),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_addr = CFG; #1 chk("R1 cfg g0", bus_rdata, 32'h0);
    bus_addr = MSK + 12'd28; #1 chk("R1 mask g7", bus_rdata, 32'hFF);
    bus_addr = PND + 12'd84; #1 chk("R1 pend g21", bus_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    rd(CFG + 12'd40, v); chk("R1 cfg g10 after release", v, 32'h0);
  endtask

  task automatic t_prep();
    for (int g = 0; g < NB; g++) wr(CFG + 12'(4 * g), 32'hFFFF_FFFF);
    for (int g = 0; g < NB; g++) wr(PND + 12'(4 * g), 32'hFF);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(CFG + 12'd84, 32'hDEAD_BEEF);
    rd(CFG + 12'd84, v); chk("R2 cfg g21 word", v, 32'hDEAD_BEEF);
    wr(CFG + 12'd84, 32'hFFFF_FFFF);
    wr(MSK + 12'd12, 32'h0000_015A);
    rd(MSK + 12'd12, v); chk("R2 mask g3 keeps 8 bits", v, 32'h5A);
    wr(MSK + 12'd12, 32'hFF);
    // bank 4 pin 6 rising: field [27:24]
    wr(CFG + 12'd16, 32'hF3FF_FFFF);
    pins[38] = 1'b1; settle();
    rd(PND + 12'd16, v); chk("R2 field pin6 bank4", v, 32'h40);
    pins[38] = 1'b0;
    wr(CFG + 12'd16, 32'hFFFF_FFFF);
    wr(PND + 12'd16, 32'hFF);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(CFG + 12'd8, 32'hFFFF_3FFF);
    @(negedge clk);
    bus_addr = PND + 12'd8; pins[19] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk); #1;
    chk("R10 not yet after 2 edges", bus_rdata, 32'h0);
    @(posedge clk); @(negedge clk); #1;
    chk("R10 set after 3 edges", bus_rdata, 32'h08);
    wr(PND + 12'd8, 32'h08); settle();
    rd(PND + 12'd8, v); chk("R3 rise clear sticks", v, 32'h0);
    pins[19] = 1'b0; settle();
    rd(PND + 12'd8, v); chk("R3 rise ignores fall", v, 32'h0);
    wr(CFG + 12'd8, 32'hFFFF_2FFF);
    pins[19] = 1'b1; settle();
    rd(PND + 12'd8, v); chk("R3 fall ignores rise", v, 32'h0);
    pins[19] = 1'b0; settle();
    rd(PND + 12'd8, v); chk("R3 fall detected", v, 32'h08);
    wr(PND + 12'd8, 32'h08);
    wr(CFG + 12'd8, 32'hFFFF_4FFF);
    pins[19] = 1'b1; settle();
    rd(PND + 12'd8, v); chk("R3 both rise", v, 32'h08);
    wr(PND + 12'd8, 32'h08);
    pins[19] = 1'b0; settle();
    rd(PND + 12'd8, v); chk("R3 both fall", v, 32'h08);
    wr(PND + 12'd8, 32'h08);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(CFG + 12'd8, 32'hFFFF_1FFF);
    pins[19] = 1'b1; settle();
    rd(PND + 12'd8, v); chk("R4 high level sets", v, 32'h08);
    wr(PND + 12'd8, 32'h08);
    rd(PND + 12'd8, v); chk("R7 event beats clear", v, 32'h08);
    pins[19] = 1'b0; settle();
    rd(PND + 12'd8, v); chk("R4 latched after level ends", v, 32'h08);
    wr(PND + 12'd8, 32'h08);
    rd(PND + 12'd8, v); chk("R4 clear sticks when inactive", v, 32'h0);
    wr(CFG + 12'd8, 32'hFFFF_0FFF); settle();
    rd(PND + 12'd8, v); chk("R4 low level sets", v, 32'h08);
    pins[19] = 1'b1; settle();
    wr(PND + 12'd8, 32'h08);
    rd(PND + 12'd8, v); chk("R4 low level cleared when high", v, 32'h0);
    pins[19] = 1'b0;
    wr(CFG + 12'd8, 32'hFFFF_FFFF);
    wr(PND + 12'd8, 32'hFF);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(CFG + 12'd8, 32'hFFFF_7FFF);
    pins[19] = 1'b1; settle(); pins[19] = 1'b0; settle();
    rd(PND + 12'd8, v); chk("R5 code 7 inert", v, 32'h0);
    wr(CFG + 12'd8, 32'hFFFF_5FFF);
    pins[19] = 1'b1; settle(); pins[19] = 1'b0; settle();
    rd(PND + 12'd8, v); chk("R5 code 5 inert", v, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(CFG + 12'd8, 32'hFFFF_3FF3);
    pins[16] = 1'b1; pins[19] = 1'b1; settle();
    rd(PND + 12'd8, v); chk("R6 two pins pending", v, 32'h09);
    wr(PND + 12'd8, 32'h00);
    rd(PND + 12'd8, v); chk("R6 write 0 keeps", v, 32'h09);
    wr(PND + 12'd8, 32'h01);
    rd(PND + 12'd8, v); chk("R6 write 1 clears one", v, 32'h08);
    wr(PND + 12'd8, 32'h08);
    rd(PND + 12'd8, v); chk("R6 write 1 clears other", v, 32'h0);
    pins[16] = 1'b0; pins[19] = 1'b0; settle();
  endtask

  task automatic t_mask();
    logic [31:0] v;
    pins[19] = 1'b1; settle();
    rd(PND + 12'd8, v); chk("R8 pending set while masked", v, 32'h08);
    chk("R8 irq low while masked", {31'b0, irq_out}, 32'h0);
    wr(MSK + 12'd8, 32'hF7); #1;
    chk("R8 irq high when unmasked", {31'b0, irq_out}, 32'h1);
    wr(MSK + 12'd8, 32'hFE); #1;
    chk("R8 irq low other bit unmasked", {31'b0, irq_out}, 32'h0);
    wr(MSK + 12'd8, 32'hF7);
    wr(PND + 12'd8, 32'h08); #1;
    chk("R8 irq low after clear", {31'b0, irq_out}, 32'h0);
    wr(MSK + 12'd8, 32'hFF);
    pins[19] = 1'b0; settle();
  endtask

  task automatic t_unused();
    logic [31:0] v;
    rd(CFG + 12'd88, v); chk("R9 bank 22 cfg reads 0", v, 32'h0);
    rd(CFG + 12'd2, v);  chk("R9 unaligned reads 0", v, 32'h0);
    rd(12'h000, v);      chk("R9 outside reads 0", v, 32'h0);
    wr(MSK + 12'd5, 32'h0);
    rd(MSK + 12'd4, v);  chk("R9 unaligned write no effect", v, 32'hFF);
    wr(MSK + 12'd88, 32'h0);
    rd(MSK + 12'd88, v); chk("R9 bank 22 mask reads 0", v, 32'h0);
    wr(CFG + 12'd1, 32'h0);
    rd(CFG, v);          chk("R9 cfg g0 untouched", v, 32'hFFFF_FFFF);
  endtask

  initial begin
    rst_n = 1'b0; pins = '0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    settle();
    t_prep();
    t_map();
    t_edges();
    t_level();
    t_disabled();
    t_clear();
    t_mask();
    t_unused();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule